// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a single-wire serial bus. The bus is one open-drain line with an external pull-up. Every bus action is a timed low pulse that the master generates. From a fixed-frequency system clock, the block builds microsecond-accurate timing. With it, the block runs a bus reset with presence detection, single write-bit and read-bit time slots, and whole-byte transfers made of eight consecutive slots.

A user issues a command by asserting a valid strobe together with an operation code and, for writes, the data. The controller raises `busy` and carries out the operation. It ends with a one-cycle `done` pulse. At that point the result is available: the presence flag after a reset, or the read data after a read. The bus side has two signals. An output enable pulls the line low when high and releases it when low; the block never drives the line high. The line's level comes back in through a synchronizer. All durations are parameters in microseconds and are scaled by the clock-frequency parameter.

Top module: `sw_bus_master`

## Requirements
- R1: In the cycle after a synchronous reset, `busy`, `done`, `presence`, `bus_oe` and `rd_data` are all zero.
- R2: A reset operation (op code 1) holds `bus_oe` high for exactly RST_LOW_US (default 500) microseconds. It then releases the line, and `done` appears exactly RST_WAIT_US (default 480) microseconds after the first released cycle.
- R3: Presence is sampled once, PRES_SMP_US (default 70) microseconds after the reset release. `presence` becomes 1 if the synchronized line was low at that point and 0 otherwise, so a slave pulse that has ended before that point, or has not yet begun, reads as absent.
- R4: A write-bit operation (op code 2) sends bit 0 of `cmd_data`. A 1 holds the line low for W1_LOW_US (default 6) microseconds and a 0 for W0_LOW_US (default 64) microseconds, so the line level 22 µs after the falling edge equals the bit.
- R5: A read-bit operation (op code 3) pulls low for RD_LOW_US (default 6) microseconds. It takes the line level, through a two-flop synchronizer, RD_SMP_US (default 14) microseconds after the slot began. The result is placed in `rd_data` bit 0, and the upper bits are cleared.
- R6: Every slot lasts SLOT_US (default 70) microseconds from its falling edge. It is followed by REC_US (default 10) microseconds of released recovery, so a bit operation keeps `busy` for 80 µs and consecutive slots in a byte start 80 µs apart.
- R7: A write-byte operation (op code 4) sends `cmd_data` as eight back-to-back write slots, least significant bit first.
- R8: A read-byte operation (op code 5) runs eight read slots and returns the bits in `rd_data`, the first received bit in bit 0.
- R9: A command presented while an operation is in progress is ignored: it starts no slot, produces no `done` and leaves `presence` unchanged.
- R10: Op codes 0, 6 and 7 are ignored: `busy` stays low and the line is not pulled.
- R11: `done` is a single-cycle pulse. In that cycle `busy` is already low, and it was high in the cycle before.
- R12: The line is only ever pulled low or released. `bus_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Operation code (1 reset, 2 write bit, 3 read bit, 4 write byte, 5 read byte) |
| cmd_data | input | DATA_W | Write data; bit 0 for single-bit writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last reset's presence sample |
| rd_data | output | DATA_W | Result of the last read operation |
| bus_oe | output | 1 | High pulls the line low; low releases it |
| bus_in | input | 1 | Raw line level (asynchronous) |

## Verification
The bench sets CLK_HZ to 1 MHz, so one clock cycle equals one microsecond. It keeps every other parameter at its default. Each low time, slot period, recovery gap and reset wait can then be compared directly with its microsecond figure in cycles. The short cycle count also lets the bench sweep 86 write-byte values and 52 read-byte values within the run. A behavioural slave samples written bits, answers read slots and places presence pulses before, around and after the presence sample point.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RESET = 3'd1,
    OP_WBIT  = 3'd2,
    OP_RBIT  = 3'd3,
    OP_WBYTE = 3'd4,
    OP_RBYTE = 3'd5
  } swb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_SLOT,
    ST_RECOV
  } swb_state_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/swb_timer.sv
module swb_timer #(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  output logic [US_W-1:0] us,
  output logic            us_last
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre;

  assign us_last = (pre == PRE_TOP);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre <= '0;
      us  <= '0;
    end else if (us_last) begin
      pre <= '0;
      if (us != '1) us <= us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  AST_US_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!restart && us_last && (us != '1)) |=> (us == $past(us) + 1'b1)); // R6

  AST_US_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (us == '0)); // R6

endmodule

// File: rtl/swb_shifter.sv
module swb_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              shift,
  input  logic              capture,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rx_word,
  output logic              empty
);

  logic [DATA_W-1:0] tx_q;
  logic [CNT_W-1:0]  left_q;

  assign tx_bit = tx_q[0];
  assign empty  = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_word <= '0;
      left_q  <= '0;
    end else begin
      if (load) begin
        tx_q   <= load_data;
        left_q <= load_count;
      end else if (shift) begin
        tx_q   <= tx_q >> 1;
        left_q <= left_q - 1'b1;
      end
      if (capture) rx_word <= {rx_bit, rx_word[DATA_W-1:1]};
    end
  end

  AST_SHIFT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    shift |-> !empty); // R7

  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst)
    left_q <= CNT_W'(DATA_W)); // R8

endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 500,
  parameter int RST_WAIT_US = 480,
  parameter int PRES_SMP_US = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 64,
  parameter int RD_LOW_US   = 6,
  parameter int RD_SMP_US   = 14,
  parameter int SLOT_US     = 70,
  parameter int REC_US      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_oe,
  input  logic              bus_in
);
  import swb_pkg::*;

  localparam int CYC    = CLK_HZ / 1_000_000;
  localparam int US_MAX = RST_LOW_US + RST_WAIT_US + SLOT_US + REC_US;
  localparam int US_W   = $clog2(US_MAX + 1);
  localparam int CNT_W  = $clog2(DATA_W + 1);

  localparam logic [US_W-1:0] T_RST  = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] T_WAIT = US_W'(RST_WAIT_US);
  localparam logic [US_W-1:0] T_PRES = US_W'(PRES_SMP_US);
  localparam logic [US_W-1:0] T_W1   = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] T_W0   = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] T_RDL  = US_W'(RD_LOW_US);
  localparam logic [US_W-1:0] T_SMP  = US_W'(RD_SMP_US);
  localparam logic [US_W-1:0] T_SLOT = US_W'(SLOT_US);
  localparam logic [US_W-1:0] T_REC  = US_W'(REC_US);

  swb_state_e        state;
  swb_op_e           op_in;
  logic              oe_q, busy_q, done_q, pres_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_op, byte_op;
  logic              rx_s;
  logic [US_W-1:0]   us;
  logic              us_last;
  logic              tmr_restart, sh_load, sh_shift, sh_capture;
  logic              tx_bit, sh_empty;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] load_data;
  logic [CNT_W-1:0]  load_count;
  logic [US_W-1:0]   low_sel;
  logic              accept;

  function automatic logic hit(input logic [US_W-1:0] cur, input logic lst,
                               input logic [US_W-1:0] n);
    return lst && (cur == n - 1'b1);
  endfunction

  swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_in),
    .q   (rx_s)
  );

  swb_timer #(.CYC_PER_US(CYC), .US_W(US_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .us      (us),
    .us_last (us_last)
  );

  swb_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (sh_load),
    .load_data  (load_data),
    .load_count (load_count),
    .shift      (sh_shift),
    .capture    (sh_capture),
    .rx_bit     (rx_s),
    .tx_bit     (tx_bit),
    .rx_word    (rx_word),
    .empty      (sh_empty)
  );

  assign op_in  = swb_op_e'(cmd_op);
  assign accept = (state == ST_IDLE) && cmd_valid && op_known(cmd_op);

  always_comb begin
    case (op_in)
      OP_WBYTE: load_data = cmd_data;
      OP_WBIT:  load_data = {{(DATA_W-1){1'b0}}, cmd_data[0]};
      default:  load_data = '1;
    endcase
    case (op_in)
      OP_WBYTE, OP_RBYTE: load_count = CNT_W'(DATA_W);
      OP_WBIT, OP_RBIT:   load_count = CNT_W'(1);
      default:            load_count = '0;
    endcase
  end

  assign low_sel = rd_op ? T_RDL : (tx_bit ? T_W1 : T_W0);

  always_comb begin
    tmr_restart = 1'b0;
    sh_load     = 1'b0;
    sh_shift    = 1'b0;
    sh_capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          tmr_restart = 1'b1;
          sh_load     = 1'b1;
        end
      end
      ST_RST_LOW: begin
        if (hit(us, us_last, T_RST)) tmr_restart = 1'b1;
      end
      ST_SLOT: begin
        if (rd_op && hit(us, us_last, T_SMP)) sh_capture = 1'b1;
        if (hit(us, us_last, T_SLOT)) begin
          tmr_restart = 1'b1;
          sh_shift    = 1'b1;
        end
      end
      ST_RECOV: begin
        if (hit(us, us_last, T_REC) && !sh_empty) tmr_restart = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      oe_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      rd_q    <= '0;
      rd_op   <= 1'b0;
      byte_op <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            busy_q  <= 1'b1;
            oe_q    <= 1'b1;
            rd_op   <= (op_in == OP_RBIT) || (op_in == OP_RBYTE);
            byte_op <= (op_in == OP_WBYTE) || (op_in == OP_RBYTE);
            state   <= (op_in == OP_RESET) ? ST_RST_LOW : ST_SLOT;
          end
        end
        ST_RST_LOW: begin
          if (hit(us, us_last, T_RST)) begin
            oe_q  <= 1'b0;
            state <= ST_RST_WAIT;
          end
        end
        ST_RST_WAIT: begin
          if (hit(us, us_last, T_PRES)) pres_q <= !rx_s;
          if (hit(us, us_last, T_WAIT)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_SLOT: begin
          if (hit(us, us_last, low_sel)) oe_q <= 1'b0;
          if (hit(us, us_last, T_SLOT)) state <= ST_RECOV;
        end
        ST_RECOV: begin
          if (hit(us, us_last, T_REC)) begin
            if (!sh_empty) begin
              oe_q  <= 1'b1;
              state <= ST_SLOT;
            end else begin
              if (rd_op)
                rd_q <= byte_op ? rx_word
                                : {{(DATA_W-1){1'b0}}, rx_word[DATA_W-1]};
              busy_q <= 1'b0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign presence = pres_q;
  assign rd_data  = rd_q;
  assign bus_oe   = oe_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_oe); // R12

  AST_RST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RST_WAIT) |-> !bus_oe); // R2

  AST_RECOV_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOV) |-> !bus_oe); // R6

  AST_SLOT_LOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SLOT) && bus_oe) |-> (us < T_W0)); // R4

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> !(($past(state) == ST_IDLE) && (state != ST_IDLE))); // R9

endmodule

// File: tb/sw_bus_master_test.sv
module sw_bus_master_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       busy, done, presence, bus_oe;
  logic [7:0] rd_data;
  logic       slave_low = 1'b0;
  wire        line = !(bus_oe || slave_low);

  int n_tests = 0;
  int n_fail  = 0;

  // slave / monitor state
  int mode = 0;
  int prev_oe = 0;
  int slot_t = 0, rel_t = 0, low_len = 0;
  int fall_n = 0, done_n = 0;
  int per_first = 1, per_cnt = 0, per_bad = 0;
  int pres_a = 0, pres_b = 0;
  int rd_idx = 0;
  logic [7:0] rd_val = 8'd0;
  logic [7:0] wr_sh = 8'd0;
  logic       wr_bit = 1'b0;

  always #10 clk = !clk;

  sw_bus_master #(.CLK_HZ(1_000_000)) uut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .busy      (busy),
    .done      (done),
    .presence  (presence),
    .rd_data   (rd_data),
    .bus_oe    (bus_oe),
    .bus_in    (line)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] d, output int bcyc);
    int guard;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    bcyc = 0; guard = 0;
    while (!done && guard < 5000) begin
      if (busy) bcyc++;
      guard++;
      @(negedge clk);
    end
    if (guard >= 5000) chk("timeout waiting for done", guard, 0);
  endtask

  // behavioural slave and line monitor, active 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst) begin
        prev_oe = 0;
      end else begin
        if (done) done_n++;
        if (bus_oe && prev_oe == 0) begin
          if (per_first == 0) begin
            per_cnt++;
            if (slot_t + 1 != 80) per_bad++;
          end
          per_first = 0;
          slot_t = 0;
          fall_n++;
          if (mode == 2) slave_low = !rd_val[rd_idx];
        end else begin
          slot_t++;
        end
        if (!bus_oe && prev_oe == 1) begin
          low_len = slot_t;
          rel_t = 0;
        end else if (rel_t < 100000) begin
          rel_t++;
        end
        if (slot_t == 22) begin
          wr_bit = line;
          wr_sh = {line, wr_sh[7:1]};
        end
        if (mode == 2 && slot_t == 30) begin
          slave_low = 1'b0;
          rd_idx = (rd_idx + 1) % 8;
        end
        if (mode == 1)
          slave_low = (low_len >= 400) && !bus_oe && (rel_t >= pres_a) && (rel_t < pres_b);
        if (mode == 0) slave_low = 1'b0;
        prev_oe = bus_oe ? 1 : 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bc, f0, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 presence", presence, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 rd_data", rd_data, 0);

    // R2/R3 reset with slave present around the sample point
    mode = 1; pres_a = 20; pres_b = 150;
    run_op(3'd1, 8'd0, bc);
    chk("R2 reset low us", low_len, 500);
    chk("R2 release to done us", rel_t, 480);
    chk("R2 busy cycles", bc, 980);
    chk("R3 presence seen", presence, 1);
    chk("R11 busy low at done", busy, 0);
    @(negedge clk);
    chk("R11 done single cycle", done, 0);

    // R3 pulse over before sample, pulse starting after sample, no slave
    pres_a = 20; pres_b = 60;
    run_op(3'd1, 8'd0, bc);
    chk("R3 early pulse absent", presence, 0);
    pres_a = 80; pres_b = 200;
    run_op(3'd1, 8'd0, bc);
    chk("R3 late pulse absent", presence, 0);
    pres_a = 20; pres_b = 150;
    run_op(3'd1, 8'd0, bc);
    chk("R3 presence again", presence, 1);
    mode = 0;
    run_op(3'd1, 8'd0, bc);
    chk("R3 no slave absent", presence, 0);

    // R4 single write bits
    run_op(3'd2, 8'hFF, bc);
    chk("R4 write1 low us", low_len, 6);
    chk("R4 write1 slave sample", wr_bit, 1);
    chk("R6 write1 busy cycles", bc, 80);
    run_op(3'd2, 8'hFE, bc);
    chk("R4 write0 low us", low_len, 64);
    chk("R4 write0 slave sample", wr_bit, 0);
    chk("R6 write0 busy cycles", bc, 80);

    // R7 write-byte sweep
    for (int v = 0; v < 256; v += 3) begin
      wr_sh = 8'd0; per_first = 1; per_cnt = 0; per_bad = 0;
      run_op(3'd4, 8'(v), bc);
      chk("R7 write byte LSB first", wr_sh, v);
      chk("R6 byte busy cycles", bc, 640);
      chk("R6 slot period count", per_cnt, 7);
      chk("R6 slot period 80us", per_bad, 0);
    end

    // R8 read-byte sweep
    mode = 2;
    for (int v = 0; v < 256; v += 5) begin
      rd_val = 8'(v); rd_idx = 0;
      run_op(3'd5, 8'd0, bc);
      chk("R8 read byte", rd_data, v);
    end

    // R5 read bits, upper bits cleared after a byte read
    rd_val = 8'hFF; rd_idx = 0;
    run_op(3'd5, 8'd0, bc);
    chk("R8 read byte all ones", rd_data, 255);
    rd_val = 8'h01; rd_idx = 0;
    run_op(3'd3, 8'd0, bc);
    chk("R5 read bit one", rd_data, 1);
    chk("R5 read low us", low_len, 6);
    chk("R6 read busy cycles", bc, 80);
    rd_val = 8'h00; rd_idx = 0;
    run_op(3'd3, 8'd0, bc);
    chk("R5 read bit zero", rd_data, 0);
    mode = 0;

    // R9 command while busy ignored
    mode = 1; pres_a = 20; pres_b = 150;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    f0 = fall_n;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    d0 = done_n;
    repeat (700) @(negedge clk);
    chk("R9 no extra slot", fall_n, f0);
    chk("R9 no extra done", done_n, d0);
    chk("R9 presence kept", presence, 1);
    chk("R12 released when idle", bus_oe, 0);
    mode = 0;

    // R10 unknown op codes
    for (int k = 0; k < 3; k++) begin
      f0 = fall_n; d0 = done_n;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = (k == 0) ? 3'd0 : ((k == 1) ? 3'd6 : 3'd7);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 busy stays low", busy, 0);
      repeat (5) @(negedge clk);
      chk("R10 no line pull", fall_n, f0);
      chk("R10 no done", done_n, d0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule